// File: doc/BRIEF.md
# Linked-List Multi-Queue Pointer Manager

This controller keeps a set of FIFO queues of buffer segments, each queue held as a singly linked list. Every piece of pointer state lives in one single-port pointer memory. That state is the next-pointer of every segment, the head word and the tail word of every queue, and the empty flags. Each memory word is one segment address plus one flag bit, and every access reads or writes one whole word.

A client issues one command at a time over a valid/ready handshake. An append command carries a queue number and a free segment address. A removal command carries a queue number and returns the segment taken from the front of that queue. The caller guarantees that a removal never targets an empty queue.

The memory behaves like a pipelined synchronous SRAM with a read latency of two edges. The sequencer reads one word first and decides from it whether the operation takes the common path or the empty-queue path. It then issues only the accesses that path needs. A parameter sets where the empty flag is kept: in the head word, in the tail word, or as two copies, one in each.

Top module: `mlq_ptr_mgr`

## Requirements
- R1: After reset, `cmd_ready` stays low while the controller marks every queue empty. This takes exactly 2*NQ cycles. After it, the first append to any queue takes the empty-queue path.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low in the next cycle and stays low until that command's access sequence has finished.
- R3: Each queue returns its segments in the order they were appended. Operations on one queue do not change the contents or order of any other queue.
- R4: Each removal (`cmd_deq`=1) produces exactly one `rsp_valid` pulse, one cycle long, with `rsp_seg` equal to the segment at the front of the queue. An append (`cmd_deq`=0) produces no pulse.
- R5: Appending to an empty queue makes the new segment both the front and the back of that queue.
- R6: Removing the last segment leaves the queue empty, and the next append to it takes the empty-queue path.
- R7: With FLAG_LOC=0 (flag in the head word), `op_acc` after a command is 4 for an append to a non-empty queue, 3 for an append to an empty queue, 4 for a removal that leaves segments behind, and 3 for a removal of the last segment.
- R8: With FLAG_LOC=1 (flag in the tail word), those four counts are 3, 3, 4 and 3.
- R9: With FLAG_LOC=2 (flag copies in both words), those four counts are 3, 3, 4 and 4.
- R10: With FLAG_LOC=2, every write that sets the flag in a queue's head word is followed in the next cycle by a write that sets the flag in that queue's tail word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cmd_deq | input | 1 | 1 = remove from the front, 0 = append at the back |
| cmd_qid | input | $clog2(NQ) | Target queue |
| cmd_seg | input | SEG_W | Segment to append (ignored for removals) |
| rsp_valid | output | 1 | One-cycle pulse carrying a removed segment |
| rsp_seg | output | SEG_W | Removed segment address |
| op_acc | output | 3 | Memory accesses made by the most recent command |

## Verification
The hardest case to reach is a removal that empties a queue while other queues still hold segments. It has to take the short path and set the flag correctly in every copy, and it must not disturb the other lists. The bench therefore interleaves two queues, drains one of them to zero while the other still holds segments, and refills it. It drives one stimulus stream into three instances, one for each flag placement, so that the access counts of the same common or empty-queue case can be compared across placements. A bench-side model of every queue supplies the expected segment and the expected path for every command.

// File: rtl/mlq_pkg.sv
package mlq_pkg;

    // Where the per-queue empty flag is stored
    typedef enum logic [1:0] {
        FL_HEAD = 2'd0,
        FL_TAIL = 2'd1,
        FL_BOTH = 2'd2
    } flag_loc_e;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_WAIT1,
        ST_CAP1,
        ST_CAP2,
        ST_RDX,
        ST_WAITX,
        ST_CAPX,
        ST_WR1,
        ST_WR2,
        ST_DONE
    } seq_st_e;

    // The first word an append reads is the one holding the flag
    function automatic bit append_reads_head(input flag_loc_e loc);
        return loc == FL_HEAD;
    endfunction

    // A removal that empties the queue needs two writes only with both copies
    function automatic bit drain_writes_both(input flag_loc_e loc);
        return loc == FL_BOTH;
    endfunction

endpackage

// File: rtl/mlq_ptr_ram.sv
module mlq_ptr_ram #(
    parameter int DW    = 7,
    parameter int AW    = 7,
    parameter int DEPTH = 80
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] pipe_q;

    // Two-stage read: array read at edge n, output register at edge n+1,
    // so the word can be sampled by the user at edge n+2.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
        if (en && !we) begin
            pipe_q <= mem[addr];
        end
        rdata <= pipe_q;
    end

endmodule

// File: rtl/mlq_seq.sv
module mlq_seq
    import mlq_pkg::*;
#(
    parameter int        SEG_W    = 6,
    parameter int        NQ       = 8,
    parameter int        AW       = 7,
    parameter flag_loc_e FLAG_LOC = FL_BOTH
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic                        cmd_deq,
    input  logic [$clog2(NQ)-1:0]       cmd_qid,
    input  logic [SEG_W-1:0]            cmd_seg,
    output logic                        mem_en,
    output logic                        mem_we,
    output logic [AW-1:0]               mem_addr,
    output logic [SEG_W:0]              mem_wdata,
    input  logic [SEG_W:0]              mem_rdata,
    output logic                        rsp_valid,
    output logic [SEG_W-1:0]            rsp_seg,
    output logic [2:0]                  op_acc
);
    localparam int NSEG  = 1 << SEG_W;
    localparam int QW    = $clog2(NQ);
    localparam int SWEEP = 2 * NQ;
    localparam logic [AW-1:0] HBASE = AW'(NSEG);
    localparam logic [AW-1:0] TBASE = AW'(NSEG + NQ);
    localparam bit RD_HEAD_FIRST = append_reads_head(FLAG_LOC);
    localparam bit DRAIN_TWO     = drain_writes_both(FLAG_LOC);

    seq_st_e          st_q;
    logic             deq_q;
    logic [QW-1:0]    q_q;
    logic [SEG_W-1:0] seg_q, head_q, tail_q, nxt_q;
    logic             exc_q;
    logic [QW:0]      init_q;
    logic [2:0]       acc_q;

    logic             rd_flag;
    logic [SEG_W-1:0] rd_ptr;
    logic             two_wr;

    assign rd_flag = mem_rdata[SEG_W];
    assign rd_ptr  = mem_rdata[SEG_W-1:0];
    assign two_wr  = !deq_q || (exc_q && DRAIN_TWO);

    function automatic logic [AW-1:0] head_at(input logic [QW-1:0] q);
        return HBASE + AW'(q);
    endfunction

    function automatic logic [AW-1:0] tail_at(input logic [QW-1:0] q);
        return TBASE + AW'(q);
    endfunction

    // Memory access issued in each state
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            ST_INIT: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = init_q[0] ? tail_at(init_q[QW:1]) : head_at(init_q[QW:1]);
                mem_wdata = {1'b1, {SEG_W{1'b0}}};
            end
            ST_RD1: begin
                mem_en   = 1'b1;
                mem_addr = (deq_q || RD_HEAD_FIRST) ? head_at(q_q) : tail_at(q_q);
            end
            ST_RD2: begin
                mem_en   = 1'b1;
                mem_addr = tail_at(q_q);
            end
            ST_RDX: begin
                mem_en   = 1'b1;
                mem_addr = deq_q ? AW'(head_q) : tail_at(q_q);
            end
            ST_WR1: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                if (!deq_q && exc_q) begin
                    mem_addr  = head_at(q_q);
                    mem_wdata = {1'b0, seg_q};
                end else if (!deq_q) begin
                    mem_addr  = AW'(tail_q);
                    mem_wdata = {1'b0, seg_q};
                end else if (exc_q && FLAG_LOC == FL_TAIL) begin
                    mem_addr  = tail_at(q_q);
                    mem_wdata = {1'b1, tail_q};
                end else if (exc_q) begin
                    mem_addr  = head_at(q_q);
                    mem_wdata = {1'b1, head_q};
                end else begin
                    mem_addr  = head_at(q_q);
                    mem_wdata = {1'b0, nxt_q};
                end
            end
            ST_WR2: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tail_at(q_q);
                mem_wdata = deq_q ? {1'b1, tail_q} : {1'b0, seg_q};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_INIT;
            init_q <= '0;
            acc_q  <= '0;
            deq_q  <= 1'b0;
            q_q    <= '0;
            seg_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            nxt_q  <= '0;
            exc_q  <= 1'b0;
        end else begin
            if (mem_en && st_q != ST_INIT) begin
                acc_q <= acc_q + 3'd1;
            end
            unique case (st_q)
                ST_INIT: begin
                    init_q <= init_q + 1'b1;
                    if (init_q == (QW+1)'(SWEEP - 1)) st_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (cmd_valid) begin
                        deq_q <= cmd_deq;
                        q_q   <= cmd_qid;
                        seg_q <= cmd_seg;
                        acc_q <= '0;
                        st_q  <= ST_RD1;
                    end
                end
                ST_RD1:   st_q <= deq_q ? ST_RD2 : ST_WAIT1;
                ST_RD2:   st_q <= ST_CAP1;
                ST_WAIT1: st_q <= ST_CAP1;
                ST_CAP1: begin
                    if (deq_q) begin
                        head_q <= rd_ptr;
                        st_q   <= ST_CAP2;
                    end else if (RD_HEAD_FIRST) begin
                        exc_q <= rd_flag;
                        st_q  <= rd_flag ? ST_WR1 : ST_RDX;
                    end else begin
                        exc_q  <= rd_flag;
                        tail_q <= rd_ptr;
                        st_q   <= ST_WR1;
                    end
                end
                ST_CAP2: begin
                    tail_q <= rd_ptr;
                    exc_q  <= (rd_ptr == head_q);
                    st_q   <= (rd_ptr == head_q) ? ST_WR1 : ST_RDX;
                end
                ST_RDX:   st_q <= ST_WAITX;
                ST_WAITX: st_q <= ST_CAPX;
                ST_CAPX: begin
                    if (deq_q) nxt_q  <= rd_ptr;
                    else       tail_q <= rd_ptr;
                    st_q <= ST_WR1;
                end
                ST_WR1:  st_q <= two_wr ? ST_WR2 : ST_DONE;
                ST_WR2:  st_q <= ST_DONE;
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (st_q == ST_IDLE);
    assign rsp_valid = (st_q == ST_DONE) && deq_q;
    assign rsp_seg   = head_q;
    assign op_acc    = acc_q;

endmodule

// File: rtl/mlq_ptr_mgr.sv
module mlq_ptr_mgr
    import mlq_pkg::*;
#(
    parameter int        SEG_W    = 6,
    parameter int        NQ       = 8,
    parameter flag_loc_e FLAG_LOC = FL_BOTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_deq,
    input  logic [$clog2(NQ)-1:0] cmd_qid,
    input  logic [SEG_W-1:0]      cmd_seg,
    output logic                  rsp_valid,
    output logic [SEG_W-1:0]      rsp_seg,
    output logic [2:0]            op_acc
);
    localparam int DEPTH = (1 << SEG_W) + 2 * NQ;
    localparam int AW    = $clog2(DEPTH);
    localparam int DW    = SEG_W + 1;

    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    mlq_seq #(
        .SEG_W   (SEG_W),
        .NQ      (NQ),
        .AW      (AW),
        .FLAG_LOC(FLAG_LOC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_deq  (cmd_deq),
        .cmd_qid  (cmd_qid),
        .cmd_seg  (cmd_seg),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid),
        .rsp_seg  (rsp_seg),
        .op_acc   (op_acc)
    );

    mlq_ptr_ram #(
        .DW   (DW),
        .AW   (AW),
        .DEPTH(DEPTH)
    ) u_ram (
        .clk  (clk),
        .en   (mem_en),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

endmodule

// File: rtl/mlq_ptr_mgr_chk.sv
module mlq_ptr_mgr_chk
    import mlq_pkg::*;
#(
    parameter int        SEG_W    = 6,
    parameter int        NQ       = 8,
    parameter int        AW       = 7,
    parameter flag_loc_e FLAG_LOC = FL_BOTH
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             rsp_valid,
    input logic [2:0]       op_acc,
    input logic             mem_en,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [SEG_W:0]   mem_wdata
);
    localparam int QW    = $clog2(NQ);
    localparam int SWEEP = 2 * NQ;
    localparam logic [AW-1:0] HB = AW'(1 << SEG_W);
    localparam logic [AW-1:0] TB = AW'((1 << SEG_W) + NQ);

    // Writes seen since reset, saturating at the sweep length
    logic [QW+1:0] wr_seen;
    always_ff @(posedge clk) begin
        if (rst) wr_seen <= '0;
        else if (mem_en && mem_we && wr_seen != (QW+2)'(SWEEP)) wr_seen <= wr_seen + 1'b1;
    end

    AST_READY_AFTER_SWEEP: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> wr_seen == (QW+2)'(SWEEP)); // R1

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R2

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4

    AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready); // R2

    AST_ACC_SANE: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && wr_seen == (QW+2)'(SWEEP)) |-> (op_acc == 3'd0 || op_acc == 3'd3 || op_acc == 3'd4)); // R7

    generate
        if (FLAG_LOC == FL_BOTH) begin : g_both
            AST_FLAG_COPIES_PAIRED: assert property (@(posedge clk) disable iff (rst)
                (mem_en && mem_we && mem_addr >= HB && mem_addr < TB && mem_wdata[SEG_W])
                |=> (mem_en && mem_we && mem_addr == $past(mem_addr) + AW'(NQ) && mem_wdata[SEG_W])); // R10
        end
    endgenerate

endmodule

bind mlq_ptr_mgr mlq_ptr_mgr_chk #(
    .SEG_W   (SEG_W),
    .NQ      (NQ),
    .AW      (AW),
    .FLAG_LOC(FLAG_LOC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid),
    .op_acc   (op_acc),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/sim_mlq_ptr_mgr.sv
module sim_mlq_ptr_mgr;
    import mlq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SEG_W = 6;
    localparam int NQ    = 8;
    localparam int QW    = $clog2(NQ);
    localparam int NI    = 3; // 0: both copies, 1: head word, 2: tail word

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_deq = 1'b0;
    logic [QW-1:0]    cmd_qid = '0;
    logic [SEG_W-1:0] cmd_seg = '0;

    logic             rdy [NI];
    logic             rv  [NI];
    logic [SEG_W-1:0] rs  [NI];
    logic [2:0]       acc [NI];

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    int mq   [NQ][64];
    int mcnt [NQ];

    always #(CLK_PERIOD/2) clk = ~clk;

    mlq_ptr_mgr #(.SEG_W(SEG_W), .NQ(NQ), .FLAG_LOC(FL_BOTH)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(rdy[0]),
        .cmd_deq(cmd_deq), .cmd_qid(cmd_qid), .cmd_seg(cmd_seg),
        .rsp_valid(rv[0]), .rsp_seg(rs[0]), .op_acc(acc[0]));

    mlq_ptr_mgr #(.SEG_W(SEG_W), .NQ(NQ), .FLAG_LOC(FL_HEAD)) u_hd (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(rdy[1]),
        .cmd_deq(cmd_deq), .cmd_qid(cmd_qid), .cmd_seg(cmd_seg),
        .rsp_valid(rv[1]), .rsp_seg(rs[1]), .op_acc(acc[1]));

    mlq_ptr_mgr #(.SEG_W(SEG_W), .NQ(NQ), .FLAG_LOC(FL_TAIL)) u_tl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(rdy[2]),
        .cmd_deq(cmd_deq), .cmd_qid(cmd_qid), .cmd_seg(cmd_seg),
        .rsp_valid(rv[2]), .rsp_seg(rs[2]), .op_acc(acc[2]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string cnt_req(input int k);
        if (k == 0) return "R9";
        if (k == 1) return "R7";
        return "R8";
    endfunction

    function automatic int exp_acc(input int k, input bit deq, input bit exc);
        if (!deq) return (exc || k != 1) ? 3 : 4;
        if (!exc) return 4;
        return (k == 0) ? 4 : 3;
    endfunction

    function automatic bit all_ready();
        return rdy[0] && rdy[1] && rdy[2];
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic do_op(input bit deq, input int q, input int seg, input string tag);
        bit exc;
        int exp_seg = 0;
        int pulses [NI];
        int got [NI];
        int guard = 0;
        if (!deq) begin
            exc = (mcnt[q] == 0);
            mq[q][mcnt[q]] = seg;
            mcnt[q]++;
        end else begin
            exp_seg = mq[q][0];
            for (int i = 1; i < mcnt[q]; i++) mq[q][i-1] = mq[q][i];
            mcnt[q]--;
            exc = (mcnt[q] == 0);
        end
        while (!all_ready() && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        cmd_valid = 1'b1;
        cmd_deq   = deq;
        cmd_qid   = QW'(q);
        cmd_seg   = SEG_W'(seg);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < NI; k++) begin
            chk(!rdy[k], "R2 ready low while busy", int'(rdy[k]), 0);
            pulses[k] = 0;
            got[k] = 0;
        end
        guard = 0;
        while (!all_ready() && guard < 100) begin
            for (int k = 0; k < NI; k++) begin
                if (rv[k]) begin
                    pulses[k]++;
                    got[k] = int'(rs[k]);
                end
            end
            @(negedge clk);
            guard++;
        end
        chk(guard < 100, {"R2 command completes ", tag}, guard, 100);
        for (int k = 0; k < NI; k++) begin
            chk(int'(acc[k]) == exp_acc(k, deq, exc), {cnt_req(k), " access count ", tag},
                int'(acc[k]), exp_acc(k, deq, exc));
            if (deq) begin
                chk(pulses[k] == 1, "R4 one response pulse", pulses[k], 1);
                chk(got[k] == exp_seg, {"R4 removed segment ", tag}, got[k], exp_seg);
            end else begin
                chk(pulses[k] == 0, "R4 no response for append", pulses[k], 0);
            end
        end
    endtask

    task automatic t_reset();
        int cyc = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NI; k++) chk(!rdy[k], "R1 ready low at reset", int'(rdy[k]), 0);
        while (!all_ready() && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 2 * NQ, "R1 sweep length", cyc, 2 * NQ);
    endtask

    task automatic t_single();
        do_op(1'b0, 0, 5, "R5 append to empty");
        do_op(1'b1, 0, 0, "R5 only segment returned");
    endtask

    task automatic t_fifo();
        do_op(1'b0, 1, 10, "R3");
        do_op(1'b0, 1, 11, "R3");
        do_op(1'b0, 1, 63, "R3");
        do_op(1'b1, 1, 0, "R3 order");
        do_op(1'b1, 1, 0, "R3 order");
        do_op(1'b1, 1, 0, "R3 order");
    endtask

    task automatic t_interleave();
        do_op(1'b0, 2, 20, "R3 two queues");
        do_op(1'b0, 3, 30, "R3 two queues");
        do_op(1'b0, 2, 21, "R3 two queues");
        do_op(1'b0, 3, 31, "R3 two queues");
        do_op(1'b1, 2, 0, "R3 queue 2");
        do_op(1'b1, 2, 0, "R6 drain queue 2");
        do_op(1'b1, 3, 0, "R3 queue 3 untouched");
        do_op(1'b0, 2, 0, "R6 refill after drain");
        do_op(1'b1, 3, 0, "R6 drain queue 3");
        do_op(1'b1, 2, 0, "R6 refilled segment");
    endtask

    task automatic t_all_queues();
        for (int q = 0; q < NQ; q++) do_op(1'b0, q, 40 + q, "R1 every queue empty");
        for (int q = NQ - 1; q >= 0; q--) do_op(1'b1, q, 0, "R3 per-queue front");
    endtask

    initial begin
        for (int q = 0; q < NQ; q++) mcnt[q] = 0;
        t_reset();
        t_single();
        t_fifo();
        t_interleave();
        t_all_queues();
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule